// File: doc/BRIEF.md
# Downward LIFO Stack with Boundary Event

This block is the storage for one stack of a stack-machine core: 256 entries of 32 bits, reached through a pointer that is a full 16-bit extension-register address and moves downward on every push. The core pushes and pops through dedicated strobes and sees the top entry and the entry below it on combinational outputs every cycle, so both operands are available without a read cycle. Software reaches every entry, and the pointer itself, through an extension-register address window. A base-address parameter places the window and sets the pointer's reset value. One copy with base 0x0200 serves the data stack. A second copy with base 0x0300, pointer register 3 and vector 0x0050 serves the return stack.

Each cycle the controller decodes its inputs into one of five operation states, OP_HOLD, OP_PUSH, OP_POP, OP_REPLACE and OP_PTRLD, and moves the pointer's low byte accordingly. OP_PUSH decrements the byte. OP_POP increments it. OP_REPLACE and OP_HOLD keep it. OP_PTRLD loads it from the window. Push and pop strobes take priority over a pointer load. The low byte value 0x00 marks the boundary. A push that lands on 0x00 from 0x01 (the stack is full) and a pop that leaves 0x00 for 0x01 (the stack was empty) each raise a one-cycle event. The event goes to an interrupt controller together with a constant vector address.

Top module: `stk_hw_stack`

## Requirements
- R1: After reset, ptr_o is 0x0200, i.e. BASE with low byte 0x00, and ovf_evt_o is low.
- R2: A push without a pop decrements the low byte of ptr_o by one, modulo 256, and leaves the upper byte at BASE[15:8]. After the edge, top_o is the pushed word and second_o is the previous top.
- R3: A pop without a push increments the low byte of ptr_o by one, modulo 256. top_o then shows the entry at the new pointer.
- R4: top_o always equals entry ptr_o[7:0], and second_o always equals entry (ptr_o[7:0]+1) mod 256, with no added latency.
- R5: ovf_evt_o is high for the single cycle after one of two operations: a push alone taken when the low byte is 0x01, or a pop alone taken when the low byte is 0x00. In every other cycle it is low.
- R6: Push and pop together keep ptr_o unchanged, overwrite the top entry with push_data_i, and raise no event.
- R7: Addresses 0x0200 to 0x02FF (upper byte equal to BASE[15:8]) form the window. A read returns entry xaddr_i[7:0] combinationally with xhit_o high. A write with xwr_i updates that entry at the clock edge.
- R8: Address 0x0002 is the pointer register. A read returns ptr_o zero-extended to 32 bits. A write loads the pointer's low byte from xwdata_i[7:0] and raises no event.
- R9: When a push and a window write target the same entry in one cycle, the entry takes the push data. When they target different entries, both writes happen.
- R10: A pointer-register write in a cycle that also pushes or pops is ignored. The pointer follows the stack operation.
- R11: Any other address gives xhit_o low and xrdata_o zero, and a write to it changes no entry and not the pointer.
- R12: ovf_vec_o always carries the vector parameter, 0x0040 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | 32 | Word to push |
| top_o | output | 32 | Entry at the pointer |
| second_o | output | 32 | Entry one above the pointer |
| ptr_o | output | 16 | Full pointer address |
| ovf_evt_o | output | 1 | One-cycle boundary event |
| ovf_vec_o | output | 16 | Constant vector address for the event |
| xaddr_i | input | 16 | Extension-register address |
| xwr_i | input | 1 | Extension-register write strobe |
| xwdata_i | input | 32 | Extension-register write data |
| xrdata_o | output | 32 | Extension-register read data |
| xhit_o | output | 1 | Address belongs to this stack |

## Verification
The properties assume the push and pop strobes are clean single-cycle controls sampled only outside reset. They also assume the pointer-register address is distinct from the window, so a pointer load never lands in storage. The stimulus keeps the strobes stable between falling edges. It preloads every entry through the window before any operation reads one, so each top and second value checked is defined. It reaches both boundary transitions by loading the pointer through the window first, instead of performing hundreds of pushes.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_PUSH,
        OP_POP,
        OP_REPLACE,
        OP_PTRLD
    } stk_op_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          ptr_wr_i,
    input  logic [IW-1:0] ptr_wdata_i,
    output logic [IW-1:0] ptr_o,
    output logic [IW-1:0] st_idx_o,
    output logic          st_we_o,
    output logic          ovf_o
);

    localparam logic [IW-1:0] EDGE_LO = '0;
    localparam logic [IW-1:0] EDGE_HI = IW'(1);

    stk_op_e       op;
    logic [IW-1:0] ptr_q, ptr_nx;
    logic          ovf_q, ovf_nx;

    // Operation decode: stack strobes win over a pointer load
    always_comb begin
        unique case ({push_i, pop_i})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_REPLACE;
            default: op = ptr_wr_i ? OP_PTRLD : OP_HOLD;
        endcase
    end

    // Next pointer, event and storage write for each operation
    always_comb begin
        ptr_nx   = ptr_q;
        ovf_nx   = 1'b0;
        st_we_o  = 1'b0;
        st_idx_o = ptr_q;
        unique case (op)
            OP_PUSH: begin
                ptr_nx   = ptr_q - 1'b1;
                st_idx_o = ptr_q - 1'b1;
                st_we_o  = 1'b1;
                ovf_nx   = (ptr_q == EDGE_HI);
            end
            OP_POP: begin
                ptr_nx = ptr_q + 1'b1;
                ovf_nx = (ptr_q == EDGE_LO);
            end
            OP_REPLACE: begin
                st_we_o = 1'b1;
            end
            OP_PTRLD: begin
                ptr_nx = ptr_wdata_i;
            end
            default: begin
                ptr_nx = ptr_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= EDGE_LO;
            ovf_q <= 1'b0;
        end else begin
            ptr_q <= ptr_nx;
            ovf_q <= ovf_nx;
        end
    end

    assign ptr_o = ptr_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/stk_xdec.sv
module stk_xdec #(
    parameter int             XW      = 16,
    parameter int             IW      = 8,
    parameter logic [XW-1:0]  BASE    = 16'h0200,
    parameter logic [XW-1:0]  PTR_NUM = 16'h0002
) (
    input  logic [XW-1:0] xaddr_i,
    output logic          win_hit_o,
    output logic          ptr_hit_o,
    output logic [IW-1:0] idx_o
);

    assign win_hit_o = (xaddr_i[XW-1:IW] == BASE[XW-1:IW]);
    assign ptr_hit_o = (xaddr_i == PTR_NUM);
    assign idx_o     = xaddr_i[IW-1:0];

endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int DW = 32,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          st_we_i,
    input  logic [IW-1:0] st_idx_i,
    input  logic [DW-1:0] st_data_i,
    input  logic          win_we_i,
    input  logic [IW-1:0] win_idx_i,
    input  logic [DW-1:0] win_data_i,
    input  logic [IW-1:0] top_idx_i,
    output logic [DW-1:0] top_o,
    output logic [DW-1:0] second_o,
    output logic [DW-1:0] win_rdata_o
);

    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] sec_idx;
    logic          win_blocked;

    // Stack write owns the entry when both ports aim at it
    assign win_blocked = st_we_i && (st_idx_i == win_idx_i);

    always_ff @(posedge clk) begin
        if (win_we_i && !win_blocked) begin
            mem[win_idx_i] <= win_data_i;
        end
        if (st_we_i) begin
            mem[st_idx_i] <= st_data_i;
        end
    end

    assign sec_idx     = top_idx_i + 1'b1;
    assign top_o       = mem[top_idx_i];
    assign second_o    = mem[sec_idx];
    assign win_rdata_o = mem[win_idx_i];

endmodule

// File: rtl/stk_hw_stack.sv
module stk_hw_stack #(
    parameter int             DW      = 32,
    parameter int             XW      = 16,
    parameter int             IW      = 8,
    parameter logic [XW-1:0]  BASE    = 16'h0200,
    parameter logic [XW-1:0]  PTR_NUM = 16'h0002,
    parameter logic [XW-1:0]  OVF_VEC = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] push_data_i,
    output logic [DW-1:0] top_o,
    output logic [DW-1:0] second_o,
    output logic [XW-1:0] ptr_o,
    output logic          ovf_evt_o,
    output logic [XW-1:0] ovf_vec_o,
    input  logic [XW-1:0] xaddr_i,
    input  logic          xwr_i,
    input  logic [DW-1:0] xwdata_i,
    output logic [DW-1:0] xrdata_o,
    output logic          xhit_o
);

    logic          win_hit, ptr_hit;
    logic [IW-1:0] x_idx, ptr_lo, st_idx;
    logic          st_we;
    logic [DW-1:0] win_rdata;

    stk_xdec #(.XW(XW), .IW(IW), .BASE(BASE), .PTR_NUM(PTR_NUM)) u_xdec (
        .xaddr_i   (xaddr_i),
        .win_hit_o (win_hit),
        .ptr_hit_o (ptr_hit),
        .idx_o     (x_idx)
    );

    stk_ctrl #(.IW(IW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .ptr_wr_i    (xwr_i && ptr_hit),
        .ptr_wdata_i (xwdata_i[IW-1:0]),
        .ptr_o       (ptr_lo),
        .st_idx_o    (st_idx),
        .st_we_o     (st_we),
        .ovf_o       (ovf_evt_o)
    );

    stk_store #(.DW(DW), .IW(IW)) u_store (
        .clk         (clk),
        .st_we_i     (st_we),
        .st_idx_i    (st_idx),
        .st_data_i   (push_data_i),
        .win_we_i    (xwr_i && win_hit),
        .win_idx_i   (x_idx),
        .win_data_i  (xwdata_i),
        .top_idx_i   (ptr_lo),
        .top_o       (top_o),
        .second_o    (second_o),
        .win_rdata_o (win_rdata)
    );

    assign ptr_o     = {BASE[XW-1:IW], ptr_lo};
    assign ovf_vec_o = OVF_VEC;
    assign xhit_o    = win_hit || ptr_hit;

    always_comb begin
        if (win_hit)      xrdata_o = win_rdata;
        else if (ptr_hit) xrdata_o = DW'(ptr_o);
        else              xrdata_o = '0;
    end

endmodule

// File: rtl/stk_hw_stack_chk.sv
module stk_hw_stack_chk #(
    parameter int            DW      = 32,
    parameter int            XW      = 16,
    parameter int            IW      = 8,
    parameter logic [XW-1:0] PTR_NUM = 16'h0002
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [DW-1:0] push_data_i,
    input logic [DW-1:0] top_o,
    input logic [DW-1:0] second_o,
    input logic [XW-1:0] ptr_o,
    input logic          ovf_evt_o,
    input logic [XW-1:0] xaddr_i,
    input logic          xwr_i,
    input logic [DW-1:0] xwdata_i
);

    AST_PUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (IW'(ptr_o[IW-1:0] + 1'b1) == $past(ptr_o[IW-1:0]))); // R2
    AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (top_o == $past(push_data_i) && second_o == $past(top_o))); // R2
    AST_POP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (IW'(ptr_o[IW-1:0] - 1'b1) == $past(ptr_o[IW-1:0]))); // R3
    AST_REPLACE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> ($stable(ptr_o) && top_o == $past(push_data_i) && !ovf_evt_o)); // R6
    AST_EVT_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && ptr_o[IW-1:0] == IW'(1)) |=> ovf_evt_o); // R5
    AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_o |-> $past(push_i != pop_i)); // R5
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (xwr_i && xaddr_i == PTR_NUM && !push_i && !pop_i)
        |=> (ptr_o[IW-1:0] == $past(xwdata_i[IW-1:0]) && !ovf_evt_o)); // R8

endmodule

bind stk_hw_stack stk_hw_stack_chk #(
    .DW(DW), .XW(XW), .IW(IW), .PTR_NUM(PTR_NUM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_data_i (push_data_i),
    .top_o       (top_o),
    .second_o    (second_o),
    .ptr_o       (ptr_o),
    .ovf_evt_o   (ovf_evt_o),
    .xaddr_i     (xaddr_i),
    .xwr_i       (xwr_i),
    .xwdata_i    (xwdata_i)
);

// File: tb/stk_hw_stack_tb.sv
module stk_hw_stack_tb;

    localparam int            DW   = 32;
    localparam int            XW   = 16;
    localparam int            IW   = 8;
    localparam int            N    = 256;
    localparam logic [XW-1:0] BASE = 16'h0200;
    localparam logic [XW-1:0] PNUM = 16'h0002;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, pop_i = 1'b0, xwr_i = 1'b0;
    logic [DW-1:0] push_data_i = '0, xwdata_i = '0;
    logic [XW-1:0] xaddr_i = '0;
    logic [DW-1:0] top_o, second_o, xrdata_o;
    logic [XW-1:0] ptr_o, ovf_vec_o;
    logic          ovf_evt_o, xhit_o;

    always #2.5 clk = ~clk;

    stk_hw_stack u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .top_o       (top_o),
        .second_o    (second_o),
        .ptr_o       (ptr_o),
        .ovf_evt_o   (ovf_evt_o),
        .ovf_vec_o   (ovf_vec_o),
        .xaddr_i     (xaddr_i),
        .xwr_i       (xwr_i),
        .xwdata_i    (xwdata_i),
        .xrdata_o    (xrdata_o),
        .xhit_o      (xhit_o)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] top;
        logic [DW-1:0] sec;
        logic [XW-1:0] ptr;
        logic          ovf;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] m [N];
    int            p = 0;
    int            n_run = 0;
    int            n_fail = 0;

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare post-edge state with the queued expectation
    always @(posedge clk) begin : monitor
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(e.tag, "ptr", DW'(ptr_o), DW'(e.ptr));
            check(e.tag, "top", top_o, e.top);
            check("R4", "second", second_o, e.sec);
            check(e.tag, "event", DW'(ovf_evt_o), DW'(e.ovf));
        end
    end

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic op(input logic pu, input logic po, input logic [DW-1:0] d,
                      input logic xw, input logic [XW-1:0] xa, input logic [DW-1:0] xd,
                      input string tag);
        exp_t e;
        int   si;
        bit   st_we, win, ev;
        @(negedge clk);
        push_i = pu; pop_i = po; push_data_i = d;
        xwr_i = xw; xaddr_i = xa; xwdata_i = xd;
        win   = (xa[XW-1:IW] == BASE[XW-1:IW]);
        st_we = pu;
        si    = (pu && !po) ? ((p + N - 1) % N) : p;
        ev    = 1'b0;
        if (xw && win && !(st_we && int'(xa[IW-1:0]) == si)) m[xa[IW-1:0]] = xd;
        if (st_we) m[si] = d;
        if (pu && !po) begin
            ev = (p == 1);
            p  = (p + N - 1) % N;
        end else if (po && !pu) begin
            ev = (p == 0);
            p  = (p + 1) % N;
        end else if (!pu && !po && xw && xa == PNUM) begin
            p = int'(xd[IW-1:0]);
        end
        e.tag = tag;
        e.top = m[p];
        e.sec = m[(p + 1) % N];
        e.ptr = {BASE[XW-1:IW], IW'(p)};
        e.ovf = ev;
        sb.push_back(e);
    endtask

    task automatic rd(input logic [XW-1:0] xa, input logic hit, input logic [DW-1:0] d,
                      input string tag);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; xwr_i = 1'b0; xaddr_i = xa;
        #1;
        check(tag, "hit", DW'(xhit_o), DW'(hit));
        check(tag, "rdata", xrdata_o, d);
    endtask

    initial begin : watchdog
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", "ptr", DW'(ptr_o), 32'h0000_0200);
        check("R1", "event", DW'(ovf_evt_o), 32'h0);
        check("R12", "vector", DW'(ovf_vec_o), 32'h0000_0040);
        rd(PNUM, 1'b1, 32'h0000_0200, "R8");

        for (int i = 0; i < N; i++) op(0, 0, '0, 1, BASE + XW'(i), 32'hA500_0000 | i, "R7");
        rd(BASE + 16'h0010, 1'b1, 32'hA500_0010, "R7");
        rd(BASE + 16'h00FF, 1'b1, 32'hA500_00FF, "R7");

        op(1, 0, 32'h1111_1111, 0, '0, '0, "R2");
        op(1, 0, 32'h2222_2222, 0, '0, '0, "R2");
        op(0, 1, '0, 0, '0, '0, "R3");
        op(1, 1, 32'h3333_3333, 0, '0, '0, "R6");
        rd(BASE + 16'h00FF, 1'b1, 32'h3333_3333, "R7");

        op(0, 0, '0, 1, PNUM, 32'h1234_5601, "R8");
        rd(PNUM, 1'b1, 32'h0000_0201, "R8");
        op(1, 0, 32'h4444_4444, 0, '0, '0, "R5");
        op(0, 0, '0, 0, '0, '0, "R5");
        op(1, 1, 32'h4545_4545, 0, '0, '0, "R6");
        op(0, 1, '0, 0, '0, '0, "R5");
        op(0, 1, '0, 0, '0, '0, "R3");

        op(1, 0, 32'h5555_5555, 1, BASE + 16'h0001, 32'hDEAD_BEEF, "R9");
        rd(BASE + 16'h0001, 1'b1, 32'h5555_5555, "R9");
        op(1, 0, 32'h5656_5656, 1, BASE + 16'h0080, 32'hCAFE_0080, "R9");
        rd(BASE + 16'h0080, 1'b1, 32'hCAFE_0080, "R9");

        op(1, 0, 32'h6666_6666, 1, PNUM, 32'h0000_00EE, "R10");
        op(0, 1, '0, 1, PNUM, 32'h0000_0033, "R10");

        rd(16'h0300, 1'b0, 32'h0, "R11");
        rd(16'h0001, 1'b0, 32'h0, "R11");
        op(0, 0, '0, 1, 16'h0300, 32'h0BAD_0BAD, "R11");
        op(0, 0, '0, 1, 16'h0003, 32'h0000_0077, "R11");
        rd(BASE + 16'h0000, 1'b1, m[0], "R11");

        @(negedge clk);
        xwr_i = 1'b0;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule